// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block takes the 32-bit address of a bus-master request arriving from PCI and decides where it lands in host memory. Four programmable windows are compared against the address in parallel. A window that hits in direct mode produces the physical address at once: the bits inside the window come from the PCI address, and the bits above come from the window's translated base. A window that hits in scatter-gather mode produces the address of the 64-bit page-table entry that a separate translation buffer must fetch. An address that no enabled window claims is reported as a miss and leads to no memory request.

Software sets up the windows through a plain register write/read port. Each window has a base register, a size mask and a translated-base register. Each result is presented one clock after the request, together with the number of the window that produced it.

Top module: `pci_dma_window_xlat`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, all windows are disabled, and an incoming request produces a miss.
- R2: Window n has its registers at byte offset n*0x100. Within that block the base register is at +0x00, the mask register is at +0x40, and the translated-base register is at +0x80. A read returns the stored value on `reg_rdata` one cycle after `reg_rd`. Only these bits are stored: base [31:20] address, [1] scatter-gather enable, [0] window enable; mask [31:20]; translated base [31:8]. All other bits read 0. Writes to any other offset, or to an address with bits [11:10] nonzero, change nothing.
- R3: Window n hits when its enable bit is 1 and PCI address bits [31:20] equal base bits [31:20] in every position where mask bits [31:20] are 0.
- R4: The mask values 0x0010_0000 (2 MB), 0x0070_0000 (8 MB) and 0x3FF0_0000 (1 GB) select windows of those sizes. An address just past the end of the window does not hit.
- R5: On a direct hit, the 34-bit physical address takes its bits inside the window (the mask bits and bits [19:0]) from the PCI address. Its remaining upper bits come from translated base [31:8] shifted left by 10. For example, a 1 GB window at 0x4000_0000 with translated base 0 maps 0x4000_0000 to 0.
- R6: On a scatter-gather hit, the entry address is the table base plus 8 times (offset within the window divided by 8 KB). The table base is translated base [31:8] shifted left by 10, with bits [14:0] forced to 0 (32 KB alignment).
- R7: A window whose enable bit is 0, including a window whose base register was written with 0, never hits.
- R8: When several enabled windows hit, the lowest-numbered window gives the result and is reported on `out_win`.
- R9: A request that hits no window raises `miss` for exactly one cycle. Neither `dm_valid` nor `sg_valid` is raised.
- R10: Exactly one of `dm_valid`, `sg_valid`, `miss` is high in the cycle after each `req_valid` cycle, and none is high after a cycle without a request. Requests may arrive back to back.
- R11: A request in the same cycle as a register write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| req_valid | input | 1 | PCI address valid |
| req_addr | input | 32 | Incoming PCI bus-master address |
| dm_valid | output | 1 | Direct-mapped hit result valid |
| sg_valid | output | 1 | Scatter-gather entry fetch request valid |
| miss | output | 1 | One-cycle pulse: no window hit |
| out_addr | output | 34 | Physical address or page-table entry address |
| out_win | output | 2 | Number of the window that hit |

## Verification
A register write and an address lookup can happen in the same clock. The key case is a write that disables the window the lookup needs. The bench provokes this by writing zero to a window's base register in the same cycle as a request that falls inside that window. The request must still be translated through the old window. A second request in the next cycle must miss. Back-to-back requests with different outcomes also check that one result never bleeds into the next.

// File: rtl/pci_xlat_pkg.sv
// Package: shared constants and the per-window configuration type.
// Assumes a 32-bit PCI address space and a 34-bit host physical space.
package pci_xlat_pkg;
    localparam int ADDR_W      = 32;   // PCI address width
    localparam int WIN_LSB     = 20;   // lowest base/mask bit (1 MB granularity)
    localparam int TB_LSB      = 8;    // lowest stored translated-base bit
    localparam int TB_SHIFT    = 2;    // translated base is PA >> (TB_SHIFT)
    localparam int PA_W        = ADDR_W + TB_SHIFT;
    localparam int PAGE_LOG2   = 13;   // 8 KB pages
    localparam int PTE_LOG2    = 3;    // 64-bit entries
    localparam int TBL_ALIGN   = 15;   // 32 KB table alignment
    localparam int REG_AW      = 12;
    localparam int STRIDE_LOG2 = 8;    // 0x100 per window
    localparam int WF_W        = ADDR_W - WIN_LSB;
    localparam int TB_W        = ADDR_W - TB_LSB;
    localparam logic [STRIDE_LOG2-1:0] OFF_BASE = 8'h00;
    localparam logic [STRIDE_LOG2-1:0] OFF_MASK = 8'h40;
    localparam logic [STRIDE_LOG2-1:0] OFF_TB   = 8'h80;

    typedef struct packed {
        logic            en;
        logic            sg;
        logic [WF_W-1:0] base;
        logic [WF_W-1:0] mask;
        logic [TB_W-1:0] tb;
    } win_cfg_t;
endpackage

// File: rtl/pci_win_regs.sv
// Register file for N_WIN windows. Each window's block sits at a 0x100 stride.
// Reads are registered and return 0 when no read is requested.
// Assumes at most one of reg_wr / reg_rd is used per cycle by software.
module pci_win_regs
    import pci_xlat_pkg::*;
#(
    parameter int N_WIN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [ADDR_W-1:0]   reg_wdata,
    output logic [ADDR_W-1:0]   reg_rdata,
    output win_cfg_t            cfg [N_WIN]
);
    localparam int IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1;

    logic [IDX_W-1:0]       sel_win;
    logic                   addr_ok;
    logic [STRIDE_LOG2-1:0] sel_off;
    logic [ADDR_W-1:0]      rd_mux;
    logic                   unused_wdata_bits;

    assign sel_win = reg_addr[STRIDE_LOG2 +: IDX_W];
    assign sel_off = reg_addr[STRIDE_LOG2-1:0];
    assign addr_ok = ((reg_addr >> (STRIDE_LOG2 + IDX_W)) == '0) &&
                     (32'(sel_win) < 32'(N_WIN));
    assign unused_wdata_bits = ^reg_wdata[TB_LSB-1:2];

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        // Per-window storage updated by writes that decode to this window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[w] <= '0;
            end else if (reg_wr && addr_ok && (32'(sel_win) == w)) begin
                case (sel_off)
                    OFF_BASE: begin
                        cfg[w].en   <= reg_wdata[0];
                        cfg[w].sg   <= reg_wdata[1];
                        cfg[w].base <= reg_wdata[ADDR_W-1:WIN_LSB];
                    end
                    OFF_MASK: cfg[w].mask <= reg_wdata[ADDR_W-1:WIN_LSB];
                    OFF_TB:   cfg[w].tb   <= reg_wdata[ADDR_W-1:TB_LSB];
                    default:  ;
                endcase
            end
        end
    end

    // Read multiplexer over the selected window and register.
    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < N_WIN; w++) begin
            if (addr_ok && (32'(sel_win) == w)) begin
                case (sel_off)
                    OFF_BASE: rd_mux = {cfg[w].base, {(WIN_LSB-2){1'b0}}, cfg[w].sg, cfg[w].en};
                    OFF_MASK: rd_mux = {cfg[w].mask, {WIN_LSB{1'b0}}};
                    OFF_TB:   rd_mux = {cfg[w].tb, {TB_LSB{1'b0}}};
                    default:  rd_mux = '0;
                endcase
            end
        end
    end

    // Registered read data, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
        else             reg_rdata <= '0;
    end
endmodule

// File: rtl/pci_win_match.sv
// One window's comparator and address former (purely combinational).
// Produces a hit flag, the mode, and either the direct physical address or
// the page-table entry address. Assumes the mask is a contiguous low run.
module pci_win_match
    import pci_xlat_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_sg,
    output logic [PA_W-1:0]   xaddr
);
    logic [ADDR_W-1:0] off_mask;
    logic [ADDR_W-1:0] offset;
    logic [PA_W-1:0]   base_pa;
    logic [PA_W-1:0]   direct_pa;
    logic [PA_W-1:0]   table_pa;
    logic [PA_W-1:0]   pte_pa;

    // Compare the fixed part of the address against the base.
    always_comb begin
        hit   = cfg.en &&
                ((addr[ADDR_W-1:WIN_LSB] & ~cfg.mask) == (cfg.base & ~cfg.mask));
        is_sg = cfg.sg;
    end

    // Form both candidate addresses and pick by mode.
    always_comb begin
        off_mask  = {cfg.mask, {WIN_LSB{1'b1}}};
        offset    = addr & off_mask;
        base_pa   = {cfg.tb, {(TB_LSB + TB_SHIFT){1'b0}}};
        direct_pa = (base_pa & ~PA_W'(off_mask)) | PA_W'(offset);
        table_pa  = {base_pa[PA_W-1:TBL_ALIGN], {TBL_ALIGN{1'b0}}};
        pte_pa    = table_pa + (PA_W'(offset >> PAGE_LOG2) << PTE_LOG2);
        xaddr     = cfg.sg ? pte_pa : direct_pa;
    end
endmodule

// File: rtl/pci_xlat_select.sv
// Priority selector and output register: the lowest-numbered hitting window
// wins; with no hit a miss pulse is produced. Results appear one cycle later.
module pci_xlat_select
    import pci_xlat_pkg::*;
#(
    parameter int N_WIN = 4,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [N_WIN-1:0]  hit,
    input  logic [N_WIN-1:0]  is_sg,
    input  logic [PA_W-1:0]   xaddr [N_WIN],
    output logic              dm_valid,
    output logic              sg_valid,
    output logic              miss,
    output logic [PA_W-1:0]   out_addr,
    output logic [IDX_W-1:0]  out_win
);
    logic             any_hit;
    logic             pick_sg;
    logic [PA_W-1:0]  pick_addr;
    logic [IDX_W-1:0] pick_win;

    // Scan from the top so the lowest index overrides.
    always_comb begin
        any_hit   = 1'b0;
        pick_sg   = 1'b0;
        pick_addr = '0;
        pick_win  = '0;
        for (int w = N_WIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                any_hit   = 1'b1;
                pick_sg   = is_sg[w];
                pick_addr = xaddr[w];
                pick_win  = IDX_W'(w);
            end
        end
    end

    // Register the outcome of each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dm_valid <= 1'b0;
            sg_valid <= 1'b0;
            miss     <= 1'b0;
            out_addr <= '0;
            out_win  <= '0;
        end else begin
            dm_valid <= req_valid && any_hit && !pick_sg;
            sg_valid <= req_valid && any_hit && pick_sg;
            miss     <= req_valid && !any_hit;
            if (req_valid) begin
                out_addr <= pick_addr;
                out_win  <= pick_win;
            end
        end
    end
endmodule

// File: rtl/pci_dma_window_xlat.sv
// Top: four PCI DMA windows with per-window direct or scatter-gather mapping.
// Register port programs the windows; translation has one cycle of latency.
module pci_dma_window_xlat
    import pci_xlat_pkg::*;
#(
    parameter int N_WIN = 4,
    localparam int IDX_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dm_valid,
    output logic              sg_valid,
    output logic              miss,
    output logic [PA_W-1:0]   out_addr,
    output logic [IDX_W-1:0]  out_win
);
    win_cfg_t         cfg   [N_WIN];
    logic [N_WIN-1:0] hit;
    logic [N_WIN-1:0] is_sg;
    logic [PA_W-1:0]  xaddr [N_WIN];

    pci_win_regs #(.N_WIN(N_WIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg(cfg)
    );

    for (genvar w = 0; w < N_WIN; w++) begin : g_match
        pci_win_match u_match (
            .cfg(cfg[w]), .addr(req_addr),
            .hit(hit[w]), .is_sg(is_sg[w]), .xaddr(xaddr[w])
        );
    end

    pci_xlat_select #(.N_WIN(N_WIN), .IDX_W(IDX_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .hit(hit), .is_sg(is_sg), .xaddr(xaddr),
        .dm_valid(dm_valid), .sg_valid(sg_valid), .miss(miss),
        .out_addr(out_addr), .out_win(out_win)
    );
endmodule

// File: rtl/pci_xlat_chk.sv
// Checker for the translator's result handshake, bound to the top module.
module pci_xlat_chk
    import pci_xlat_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            dm_valid,
    input logic            sg_valid,
    input logic            miss,
    input logic [PA_W-1:0] out_addr
);
    // R9
    miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (!dm_valid && !sg_valid));
    // R10
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($countones({dm_valid, sg_valid, miss}) == 1));
    // R10
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(dm_valid || sg_valid || miss));
    // R6
    pte_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sg_valid |-> (out_addr[PTE_LOG2-1:0] == '0));
endmodule

bind pci_dma_window_xlat pci_xlat_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dm_valid(dm_valid),
    .sg_valid(sg_valid), .miss(miss), .out_addr(out_addr)
);

// File: tb/test_pci_dma_window_xlat.sv
module test_pci_dma_window_xlat;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        dm_valid, sg_valid, miss;
    logic [33:0] out_addr;
    logic [1:0]  out_win;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_dma_window_xlat i_pci_dma_window_xlat (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .dm_valid(dm_valid), .sg_valid(sg_valid), .miss(miss),
        .out_addr(out_addr), .out_win(out_win)
    );

    localparam int K_DM = 0, K_SG = 1, K_MISS = 2;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic check_result(input int kind, input logic [33:0] ea, input logic [1:0] ew, input string req);
        logic [2:0] got, want;
        got  = {dm_valid, sg_valid, miss};
        want = (kind == K_DM) ? 3'b100 : (kind == K_SG) ? 3'b010 : 3'b001;
        check(got == want, {req, " kind"}, 64'(got), 64'(want));
        if (kind != K_MISS) begin
            check(out_addr == ea, {req, " addr"}, 64'(out_addr), 64'(ea));
            check(out_win == ew, {req, " window"}, 64'(out_win), 64'(ew));
        end
    endtask

    task automatic xlat(input logic [31:0] a, input int kind, input logic [33:0] ea, input logic [1:0] ew, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check_result(kind, ea, ew, req);
    endtask

    // R1: reset state
    task automatic t_reset;
        check({dm_valid, sg_valid, miss} == 3'b000, "R1 outputs idle", 64'({dm_valid, sg_valid, miss}), 0);
        rd_check(12'h000, 32'h0, "R1 base0");
        rd_check(12'h340, 32'h0, "R1 mask3");
        xlat(32'h4000_0000, K_MISS, 0, 0, "R1 request after reset");
    endtask

    // R2: register map and stored bits
    task automatic t_regmap;
        wr(12'h100, 32'h4000_0001);
        rd_check(12'h100, 32'h4000_0001, "R2 base1 readback");
        wr(12'h140, 32'hFFFF_FFFF);
        rd_check(12'h140, 32'hFFF0_0000, "R2 mask1 stored bits");
        wr(12'h140, 32'h3FF0_0000);
        wr(12'h180, 32'h0000_00FF);
        rd_check(12'h180, 32'h0, "R2 tbase1 low bits dropped");
        wr(12'h400, 32'hFFFF_FFFF);
        rd_check(12'h000, 32'h0, "R2 out-of-range write ignored");
        rd_check(12'h400, 32'h0, "R2 out-of-range read");
        wr(12'h010, 32'hFFFF_FFFF);
        rd_check(12'h000, 32'h0, "R2 unmapped offset write ignored");
    endtask

    // R3 R4 R5: direct windows
    task automatic t_direct;
        xlat(32'h4000_0000, K_DM, 34'h0, 2'd1, "R5 1GB at 1GB start");
        xlat(32'h7FFF_FFF8, K_DM, 34'h3FFF_FFF8, 2'd1, "R4 1GB window top");
        xlat(32'h8000_0000, K_MISS, 0, 0, "R4 past 1GB end");
        wr(12'h000, 32'h0080_0001);
        wr(12'h040, 32'h0070_0000);
        wr(12'h080, 32'h1000_0000);
        xlat(32'h00AB_CDEF, K_DM, 34'h0_402B_CDEF, 2'd0, "R3 8MB direct with tbase");
        xlat(32'h0100_0000, K_MISS, 0, 0, "R4 past 8MB end");
        xlat(32'h007F_FFFF, K_MISS, 0, 0, "R3 below 8MB base");
    endtask

    // R6 R4: scatter-gather window 2 MB at 128 MB
    task automatic t_sg;
        wr(12'h200, 32'h0800_0003);
        wr(12'h240, 32'h0010_0000);
        wr(12'h280, 32'h4000_27FF);
        rd_check(12'h280, 32'h4000_2700, "R2 tbase2 readback");
        xlat(32'h0800_0000, K_SG, 34'h1_0000_8000, 2'd2, "R6 first entry, alignment");
        xlat(32'h0800_3FFF, K_SG, 34'h1_0000_8008, 2'd2, "R6 second page");
        xlat(32'h081F_E000, K_SG, 34'h1_0000_87F8, 2'd2, "R6 last page");
        xlat(32'h0820_0000, K_MISS, 0, 0, "R4 past 2MB end");
    endtask

    // R8: priority among overlapping windows
    task automatic t_priority;
        wr(12'h300, 32'h0000_0001);
        wr(12'h340, 32'h3FF0_0000);
        wr(12'h380, 32'h0);
        xlat(32'h0080_0004, K_DM, 34'h0_4000_0004, 2'd0, "R8 window0 over window3");
        xlat(32'h0800_0008, K_SG, 34'h1_0000_8000, 2'd2, "R8 window2 over window3");
        xlat(32'h0100_0000, K_DM, 34'h0_0100_0000, 2'd3, "R8 window3 alone");
    endtask

    // R7 R9: disabling, miss pulse width
    task automatic t_disable;
        wr(12'h000, 32'h0);
        xlat(32'h0080_0004, K_DM, 34'h0_0080_0004, 2'd3, "R7 base0 zero falls through");
        wr(12'h300, 32'h0000_0002);
        xlat(32'h0100_0000, K_MISS, 0, 0, "R7 enable bit clear");
        @(negedge clk);
        check(miss == 1'b0, "R9 miss lasts one cycle", 64'(miss), 0);
    endtask

    // R11: write and lookup in the same cycle
    task automatic t_same_cycle;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h100; reg_wdata = 32'h0;
        req_valid = 1'b1; req_addr = 32'h4000_0010;
        @(negedge clk);
        reg_wr = 1'b0; req_valid = 1'b0;
        check_result(K_DM, 34'h10, 2'd1, "R11 old config used");
        xlat(32'h4000_0010, K_MISS, 0, 0, "R11 new config next");
    endtask

    // R10: back-to-back requests
    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0800_2000;
        @(negedge clk);
        req_addr = 32'h0200_0000;
        check_result(K_SG, 34'h1_0000_8008, 2'd2, "R10 first of pair");
        @(negedge clk);
        req_valid = 1'b0;
        check_result(K_MISS, 0, 0, "R10 second of pair");
        @(negedge clk);
        check({dm_valid, sg_valid, miss} == 3'b000, "R10 idle after pair", 64'({dm_valid, sg_valid, miss}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_direct();
        t_sg();
        t_priority();
        t_disable();
        t_same_cycle();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule